// File: doc/BRIEF.md
# Clock Synthesizer Divider Solver

This block turns a requested output frequency into the divider settings of a clock synthesizer. The synthesizer produces (M+2)·Fref / (2^P · (N1+2)), where P is a 2-bit post-divide code, M a 7-bit feedback count and N1 a 5-bit reference count. A request carries the wanted output frequency and the reference frequency, both as unsigned integers in kHz, plus a flag that pins the post-divide code to ÷4.

The solver first screens the inputs against the reference and output limits. It then picks the post-divide code. After that it walks N1 through all 32 values, one value per clock. For each N1 it rounds M to the nearest integer and keeps the candidate that meets the phase-detector and VCO windows and has the smallest output error. Errors are compared by cross-multiplication, so no divider sits in the compare path. The answer comes back as the M byte and the packed N byte. It also carries the absolute output error in Hz, or an error flag with all data zero.

Both edges use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the solver is idle, so a new request waits through the whole search. A result stays on the response port, unchanged, until the consumer raises `rsp_ready`. No second request is taken before that.

Top module: `pll_div_solver`

## Requirements
- R1: Unless forced, the post-divide code is the highest of 3 (÷8), 2 (÷4), 1 (÷2) and 0 (÷1) whose divisor times the requested output is strictly below 270000 kHz.
- R2: When `req_force_div4` is high at acceptance, the returned post-divide code is 2 (÷4).
- R3: `rsp_m[6:0]` holds M. `rsp_n` bit 7 is 0, bits 6:5 hold the post-divide code and bits 4:0 hold N1.
- R4: For each N1, M is round(fout·2^P·(N1+2)/fref) − 2, with exact halves rounded up, then clamped to 0..127.
- R5: A candidate is legal only if 600·(N1+2) ≤ fref ≤ 8000·(N1+2) and 60000·(N1+2) ≤ (M+2)·fref ≤ 270000·(N1+2), all in kHz.
- R6: The result is the legal candidate with the smallest absolute output error. On a tie, the lowest N1 wins.
- R7: `rsp_err_hz` is floor(1000·|(M+2)·fref − fout·2^P·(N1+2)| / (2^P·(N1+2))).
- R8: A request is rejected if the reference is not strictly between 2000 and 25000 kHz, or if the output is 0 or above 35000 kHz. A rejected request returns `rsp_bad`=1 with M, N and error all zero.
- R9: If no N1 gives a legal candidate, the solver returns `rsp_bad`=1 with M, N and error all zero.
- R10: Each accepted request gives exactly one response. `req_ready` and `rsp_valid` are never high together. While `rsp_valid` is high and `rsp_ready` is low, the response fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Solver idle and able to take a request |
| req_fout_khz | input | 16 | Requested output frequency, kHz |
| req_fref_khz | input | 16 | Reference frequency, kHz |
| req_force_div4 | input | 1 | Pin the post-divide code to ÷4 |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_m | output | 7 | M field |
| rsp_n | output | 8 | Packed N byte: 0, post-divide code, N1 |
| rsp_err_hz | output | 32 | Absolute output error, Hz, truncated |
| rsp_bad | output | 1 | Request rejected or unsolvable |

## Verification
The bench sweeps several reference frequencies, including both sides of each reference limit and a common 14318 kHz crystal. For each one it tries a ladder of output frequencies, with and without the force flag. The ladder includes the 33749/33750 kHz step where ÷8 gives way to ÷4, the 35000/35001 kHz output limit, zero, and very small outputs. Small outputs on a low reference leave no legal candidate, which separates the unsolvable path from the input-limit path. The force flag shows whether the pinned code overrides the selection rule. Responses are held back for a varying number of cycles, which shows whether a result can change or be lost under back-pressure.

// File: rtl/pll_solver_pkg.sv
package pll_solver_pkg;

  // Solver control phases.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_FINAL  = 2'd2,
    ST_RESP   = 2'd3
  } solve_state_e;

  // Post-divide code meaning ÷4, used by the force input.
  localparam logic [1:0] CODE_DIV4 = 2'd2;

endpackage

// File: rtl/pll_postdiv_sel.sv
module pll_postdiv_sel #(
  parameter int F_W         = 16,
  parameter int WW          = 36,
  parameter int VCO_MAX_KHZ = 270000
) (
  input  logic [F_W-1:0] fout,
  input  logic           force_div4,
  output logic [1:0]     code
);
  import pll_solver_pkg::*;

  // Ascending scan: the last code that still fits is the largest one.
  always_comb begin
    code = 2'd0;
    for (int c = 0; c < 4; c++) begin
      if ((WW'(fout) << c) < WW'(VCO_MAX_KHZ)) code = 2'(c);
    end
    if (force_div4) code = CODE_DIV4;
  end

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
  parameter int F_W         = 16,
  parameter int M_W         = 7,
  parameter int N1_W        = 5,
  parameter int WW          = 36,
  parameter int PD_MIN_KHZ  = 600,
  parameter int PD_MAX_KHZ  = 8000,
  parameter int VCO_MIN_KHZ = 60000,
  parameter int VCO_MAX_KHZ = 270000
) (
  input  logic [F_W-1:0]  fout,
  input  logic [F_W-1:0]  fref,
  input  logic [1:0]      code,
  input  logic [N1_W-1:0] n1,
  output logic [M_W-1:0]  m,
  output logic [WW-1:0]   den,
  output logic [WW-1:0]   err_num,
  output logic            ok
);
  localparam logic [WW-1:0] M_MAX = WW'((1 << M_W) - 1);

  logic [WW-1:0] nd, tgt, q, divisor, ach;

  always_comb begin
    nd      = WW'(n1) + WW'(2);
    den     = nd << code;
    tgt     = WW'(fout) * den;
    divisor = (fref == '0) ? WW'(2) : (WW'(fref) << 1);
    q       = ((tgt << 1) + WW'(fref)) / divisor;   // nearest M+2, halves up
    if (q < WW'(2))               m = '0;
    else if (q - WW'(2) > M_MAX)  m = M_MAX[M_W-1:0];
    else                          m = M_W'(q - WW'(2));
    ach     = (WW'(m) + WW'(2)) * WW'(fref);
    err_num = (ach >= tgt) ? (ach - tgt) : (tgt - ach);
    ok      = (WW'(fref) >= WW'(PD_MIN_KHZ) * nd) &&
              (WW'(fref) <= WW'(PD_MAX_KHZ) * nd) &&
              (ach >= WW'(VCO_MIN_KHZ) * nd) &&
              (ach <= WW'(VCO_MAX_KHZ) * nd);
  end

endmodule

// File: rtl/pll_best_keep.sv
module pll_best_keep #(
  parameter int M_W  = 7,
  parameter int N1_W = 5,
  parameter int WW   = 36
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            step,
  input  logic            cand_ok,
  input  logic [M_W-1:0]  cand_m,
  input  logic [N1_W-1:0] cand_n1,
  input  logic [WW-1:0]   cand_num,
  input  logic [WW-1:0]   cand_den,
  output logic            best_have,
  output logic [M_W-1:0]  best_m,
  output logic [N1_W-1:0] best_n1,
  output logic [WW-1:0]   best_num,
  output logic [WW-1:0]   best_den
);
  localparam int XW = 2 * WW;

  logic [XW-1:0] lhs, rhs;
  logic          better;

  // num_a/den_a < num_b/den_b  <=>  num_a*den_b < num_b*den_a
  always_comb begin
    lhs    = XW'(cand_num) * XW'(best_den);
    rhs    = XW'(best_num) * XW'(cand_den);
    better = cand_ok && (!best_have || (lhs < rhs));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_have <= 1'b0;
      best_m    <= '0;
      best_n1   <= '0;
      best_num  <= '0;
      best_den  <= '0;
    end else if (clear) begin
      best_have <= 1'b0;
    end else if (step && better) begin
      best_have <= 1'b1;
      best_m    <= cand_m;
      best_n1   <= cand_n1;
      best_num  <= cand_num;
      best_den  <= cand_den;
    end
  end

endmodule

// File: rtl/pll_div_solver.sv
module pll_div_solver #(
  parameter int F_W         = 16,
  parameter int M_W         = 7,
  parameter int N1_W        = 5,
  parameter int REF_MIN_KHZ = 2000,
  parameter int REF_MAX_KHZ = 25000,
  parameter int OUT_MAX_KHZ = 35000,
  parameter int PD_MIN_KHZ  = 600,
  parameter int PD_MAX_KHZ  = 8000,
  parameter int VCO_MIN_KHZ = 60000,
  parameter int VCO_MAX_KHZ = 270000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [F_W-1:0]    req_fout_khz,
  input  logic [F_W-1:0]    req_fref_khz,
  input  logic              req_force_div4,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [M_W-1:0]    rsp_m,
  output logic [N1_W+2:0]   rsp_n,
  output logic [31:0]       rsp_err_hz,
  output logic              rsp_bad
);
  import pll_solver_pkg::*;

  localparam int WW = F_W + M_W + N1_W + 8;
  localparam int XW = 2 * WW;
  localparam logic [N1_W-1:0] N1_LAST = N1_W'((1 << N1_W) - 1);

  solve_state_e   state;
  logic [F_W-1:0] fout_q, fref_q;
  logic           force_q;
  logic [N1_W-1:0] n1_q;
  logic [1:0]     code;
  logic           in_bad, accept;

  logic [M_W-1:0]  c_m;
  logic [WW-1:0]   c_den, c_num;
  logic            c_ok;
  logic            b_have;
  logic [M_W-1:0]  b_m;
  logic [N1_W-1:0] b_n1;
  logic [WW-1:0]   b_num, b_den;
  logic [XW-1:0]   err_scaled;

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign accept    = req_valid && req_ready;

  always_comb begin
    in_bad = !((32'(req_fref_khz) > 32'(REF_MIN_KHZ)) &&
               (32'(req_fref_khz) < 32'(REF_MAX_KHZ))) ||
             (req_fout_khz == '0) ||
             (32'(req_fout_khz) > 32'(OUT_MAX_KHZ));
    err_scaled = (b_den == '0) ? '0 : (XW'(b_num) * XW'(1000)) / XW'(b_den);
  end

  pll_postdiv_sel #(.F_W(F_W), .WW(WW), .VCO_MAX_KHZ(VCO_MAX_KHZ)) u_sel (
    .fout(fout_q), .force_div4(force_q), .code(code)
  );

  pll_cand_eval #(
    .F_W(F_W), .M_W(M_W), .N1_W(N1_W), .WW(WW),
    .PD_MIN_KHZ(PD_MIN_KHZ), .PD_MAX_KHZ(PD_MAX_KHZ),
    .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ)
  ) u_eval (
    .fout(fout_q), .fref(fref_q), .code(code), .n1(n1_q),
    .m(c_m), .den(c_den), .err_num(c_num), .ok(c_ok)
  );

  pll_best_keep #(.M_W(M_W), .N1_W(N1_W), .WW(WW)) u_best (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step(state == ST_SEARCH),
    .cand_ok(c_ok), .cand_m(c_m), .cand_n1(n1_q), .cand_num(c_num),
    .cand_den(c_den), .best_have(b_have), .best_m(b_m), .best_n1(b_n1),
    .best_num(b_num), .best_den(b_den)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      fout_q     <= '0;
      fref_q     <= '0;
      force_q    <= 1'b0;
      n1_q       <= '0;
      rsp_m      <= '0;
      rsp_n      <= '0;
      rsp_err_hz <= '0;
      rsp_bad    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          fout_q  <= req_fout_khz;
          fref_q  <= req_fref_khz;
          force_q <= req_force_div4;
          n1_q    <= '0;
          if (in_bad) begin
            rsp_m      <= '0;
            rsp_n      <= '0;
            rsp_err_hz <= '0;
            rsp_bad    <= 1'b1;
            state      <= ST_RESP;
          end else begin
            state <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          n1_q <= n1_q + 1'b1;
          if (n1_q == N1_LAST) state <= ST_FINAL;
        end
        ST_FINAL: begin
          if (b_have) begin
            rsp_m      <= b_m;
            rsp_n      <= {1'b0, code, b_n1};
            rsp_err_hz <= 32'(err_scaled);
            rsp_bad    <= 1'b0;
          end else begin
            rsp_m      <= '0;
            rsp_n      <= '0;
            rsp_err_hz <= '0;
            rsp_bad    <= 1'b1;
          end
          state <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_div_solver_chk.sv
module pll_div_solver_chk #(
  parameter int F_W         = 16,
  parameter int M_W         = 7,
  parameter int N1_W        = 5,
  parameter int VCO_MIN_KHZ = 60000,
  parameter int VCO_MAX_KHZ = 270000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [F_W-1:0]    req_fref_khz,
  input logic              req_force_div4,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [M_W-1:0]    rsp_m,
  input logic [N1_W+2:0]   rsp_n,
  input logic [31:0]       rsp_err_hz,
  input logic              rsp_bad
);
  localparam int WW = F_W + M_W + N1_W + 8;

  logic [F_W-1:0] fref_l;
  logic           force_l;
  logic [WW-1:0]  ach, nd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fref_l  <= '0;
      force_l <= 1'b0;
    end else if (req_valid && req_ready) begin
      fref_l  <= req_fref_khz;
      force_l <= req_force_div4;
    end
  end

  always_comb begin
    nd  = WW'(rsp_n[N1_W-1:0]) + WW'(2);
    ach = (WW'(rsp_m) + WW'(2)) * WW'(fref_l);
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_m) && $stable(rsp_n)
      && $stable(rsp_err_hz) && $stable(rsp_bad));

  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  a_r3_n_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rsp_n[N1_W+2]);

  a_r8_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_bad |-> rsp_m == '0 && rsp_n == '0 && rsp_err_hz == '0);

  a_r2_forced: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_bad && force_l |-> rsp_n[N1_W+1:N1_W] == 2'd2);

  a_r5_vco_window: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_bad |-> ach >= WW'(VCO_MIN_KHZ) * nd
      && ach <= WW'(VCO_MAX_KHZ) * nd);

endmodule

bind pll_div_solver pll_div_solver_chk #(
  .F_W(F_W), .M_W(M_W), .N1_W(N1_W),
  .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ)
) u_chk (.*);

// File: tb/pll_div_solver_test.sv
module pll_div_solver_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_fout_khz = '0;
  logic [15:0] req_fref_khz = '0;
  logic        req_force_div4 = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [6:0]  rsp_m;
  logic [7:0]  rsp_n;
  logic [31:0] rsp_err_hz;
  logic        rsp_bad;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  pll_div_solver uut (.*);

  task automatic check(input string tag, input longint got, input longint exp,
                       input int fo, input int fr);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s fout=%0d fref=%0d actual=%0d expected=%0d", tag, fo, fr, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Expected result derived from the requirement text.
  task automatic model(input longint fo, input longint fr, input bit frc,
                       output longint em, output longint en, output longint eerr,
                       output bit ebad, output bit in_bad);
    longint code, nd, den, tgt, q, m, ach, err, bm, bn1, bnum, bden;
    bit have;
    em = 0; en = 0; eerr = 0; ebad = 1; have = 0;
    bm = 0; bn1 = 0; bnum = 0; bden = 1;
    in_bad = !(fr > 2000 && fr < 25000) || fo == 0 || fo > 35000;
    if (in_bad) return;
    code = 0;
    for (int c = 0; c < 4; c++) if ((fo << c) < 270000) code = c;
    if (frc) code = 2;
    for (int n1 = 0; n1 < 32; n1++) begin
      nd  = n1 + 2;
      den = nd << code;
      tgt = fo * den;
      q   = (2 * tgt + fr) / (2 * fr);
      m   = (q < 2) ? 0 : ((q - 2 > 127) ? 127 : q - 2);
      ach = (m + 2) * fr;
      err = (ach >= tgt) ? ach - tgt : tgt - ach;
      if (fr >= 600 * nd && fr <= 8000 * nd && ach >= 60000 * nd && ach <= 270000 * nd)
        if (!have || err * bden < bnum * den) begin
          have = 1; bm = m; bn1 = n1; bnum = err; bden = den;
        end
    end
    if (have) begin
      ebad = 0; em = bm; en = code * 32 + bn1; eerr = bnum * 1000 / bden;
    end
  endtask

  task automatic run_vec(input int fo, input int fr, input bit frc, input int stall);
    longint em, en, eerr;
    bit ebad, in_bad;
    logic [6:0] hm; logic [7:0] hn; logic [31:0] he; logic hb;
    model(fo, fr, frc, em, en, eerr, ebad, in_bad);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_fout_khz = 16'(fo); req_fref_khz = 16'(fr); req_force_div4 = frc;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    hm = rsp_m; hn = rsp_n; he = rsp_err_hz; hb = rsp_bad;
    for (int s = 0; s < stall; s++) @(negedge clk);
    // R10: result held under back-pressure
    check("R10 hold", {rsp_valid, rsp_m, rsp_n, rsp_err_hz, rsp_bad},
          {1'b1, hm, hn, he, hb}, fo, fr);
    check(in_bad ? "R8 reject flag" : "R9 unsolvable flag", rsp_bad, ebad, fo, fr);
    check("R4 M field", rsp_m, em, fo, fr);
    check(frc ? "R2 forced code" : "R1 post-divide code", rsp_n[6:5], en >> 5, fo, fr);
    check("R6 best N1", rsp_n[4:0], en & 31, fo, fr);
    check("R3 N byte top bit", rsp_n[7], 0, fo, fr);
    check("R7 error Hz", rsp_err_hz, eerr, fo, fr);
    if (!rsp_bad) begin
      longint nd2 = longint'(rsp_n[4:0]) + 2;
      longint a2  = (longint'(rsp_m) + 2) * fr;
      check("R5 limits", (fr >= 600*nd2 && fr <= 8000*nd2 && a2 >= 60000*nd2 && a2 <= 270000*nd2), 1, fo, fr);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    // R10: one response per request, solver idle again
    check("R10 single response", {rsp_valid, req_ready}, 2'b01, fo, fr);
  endtask

  initial begin
    int frefs [8] = '{2000, 2001, 5000, 8000, 14318, 20000, 24999, 25000};
    int extra [8] = '{0, 1, 600, 25175, 33749, 33750, 35000, 35001};
    int stall = 0;
    #1;
    check("R10 reset ready", req_ready, 1, 0, 0);
    check("R10 reset valid", rsp_valid, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int f = 0; f < 8; f++) begin
      for (int k = 0; k < 2; k++) begin
        for (int fo = 250; fo <= 36000; fo += 1750) begin
          run_vec(fo, frefs[f], k[0], stall);
          stall = (stall + 1) % 4;
        end
        for (int e = 0; e < 8; e++) begin
          run_vec(extra[e], frefs[f], k[0], stall);
          stall = (stall + 1) % 4;
        end
      end
    end
    finish_run();
  end

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    finish_run();
  end

endmodule